// File: doc/BRIEF.md
# Smart Card Contact Pin Controller

This block manages the contact pins of a smart card socket from a single 8-bit control register. It works in one of two pin modes. In bridged mode, the host-side data, C4 and C8 lines are joined to the matching card contacts, so a low level on either side shows up on the other. In isolated mode, the host lines are released, and each card contact is driven from its own software bit. This lets firmware bit-bang the card while the host lines serve another interface.

The block also produces the card clock. The card clock either follows a running source clock, generated elsewhere in the `clk_i` domain, or it holds a static level set by software. Switching between the two never produces a shortened high or low phase. All pins are open-drain: an enable output of 1 means the pad pulls low, and 0 means the pad is released to its pull-up. Synchronized copies of the card contact levels are made available as a status vector.

Top module: `sc_pin_ctrl`

## Requirements
- R1: A write with `wr_en_i` loads bits 6..0 of `wr_data_i` into the control register. `rd_data_o` returns the register, and bit 7 always reads 0 whatever was written. Field positions: 6 isolate, 5 clock-hold, 4 card reset, 3 C8 bit, 2 C4 bit, 1 clock level, 0 data bit.
- R2: After reset the register reads 0x60 (isolate=1, clock-hold=1, all else 0). All card contacts are pulled low, the host lines are released, the card clock is 0 and the card reset pin is low.
- R3: With isolate=1, each card contact enable (index 0 data, 1 C4, 2 C8) is the inverse of its software bit, and every host enable is 0, whatever the host lines do. This takes effect one cycle after the register changes.
- R4: With isolate=0, a low on a released host line makes the block pull the matching card contact low, and a low on a released card contact makes it pull the host line low. The host and card enables of one pin are never both 1. When both sides are pulled low externally at once, the card side is driven and the host side is not.
- R5: With clock-hold=1, the card clock settles to the clock level bit and stays there.
- R6: With clock-hold=0, the card clock equals the source clock delayed by one `clk_i` cycle.
- R7: The card clock changes only one cycle after a change of the source clock or of the clock level bit. A change of clock-hold completes within 8 cycles of the write when the source has a period of 4 cycles.
- R8: `card_rst_o` equals the card reset bit, so a 0 drives the card reset pin low.
- R9: `status_o` presents the card contact input levels through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| src_clk_i | input | 1 | Running card clock source, synchronous to clk_i |
| host_in_i | input | 3 | Host line levels (data, C4, C8) |
| host_oe_o | output | 3 | Host line pull-low enables |
| card_in_i | input | 3 | Card contact levels (data, C4, C8) |
| card_oe_o | output | 3 | Card contact pull-low enables |
| card_clk_o | output | 1 | Card clock |
| card_rst_o | output | 1 | Card reset level |
| status_o | output | 3 | Synchronized card contact levels |

## Verification
The hardest case to reach is the moment when the clock-hold bit changes while the source clock sits at the opposite level from the hold level. At that moment the switch has to wait for a source edge. The bench runs the source at a period of four cycles and issues hold and release writes with the level bit both matching and opposing the source phase. A run-length monitor then checks that no high or low phase of the card clock is shorter than a half period. A second hard case is a simultaneous low on both sides of a bridged pin, followed by the host releasing. The bench models the open-drain wires and drives this sequence on purpose.

// File: rtl/sc_pin_pkg.sv
package sc_pin_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_PINS = 3;

  typedef struct packed {
    logic rsvd;
    logic isolate;
    logic clk_hold;
    logic card_rst;
    logic c8_bit;
    logic c4_bit;
    logic clk_lvl;
    logic io_bit;
  } ctrl_reg_t;

  localparam ctrl_reg_t CTRL_RESET = '{rsvd: 1'b0, isolate: 1'b1, clk_hold: 1'b1,
                                       card_rst: 1'b0, c8_bit: 1'b0, c4_bit: 1'b0,
                                       clk_lvl: 1'b0, io_bit: 1'b0};

  typedef enum logic {CK_RUN = 1'b0, CK_HOLD = 1'b1} ck_state_e;
endpackage

// File: rtl/sc_ctrl_reg.sv
module sc_ctrl_reg
  import sc_pin_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output ctrl_reg_t        ctrl_o,
  output logic [REG_W-1:0] rd_data_o
);
  ctrl_reg_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RESET;
    else if (wr_en_i) ctrl_q <= ctrl_reg_t'({1'b0, wr_data_i[REG_W-2:0]});
  end

  assign ctrl_o    = ctrl_q;
  assign rd_data_o = ctrl_q;

  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[REG_W-1] == 1'b0));
endmodule

// File: rtl/sc_pin_route.sv
module sc_pin_route #(
  parameter int unsigned PINS = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            isolate_i,
  input  logic [PINS-1:0] sw_bits_i,
  input  logic [PINS-1:0] host_in_i,
  input  logic [PINS-1:0] card_in_i,
  output logic [PINS-1:0] host_oe_o,
  output logic [PINS-1:0] card_oe_o
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic host_oe_q, card_oe_q;
    logic card_oe_d, host_oe_d;

    // card side wins when both sides go low together
    always_comb begin
      if (isolate_i) begin
        card_oe_d = ~sw_bits_i[p];
        host_oe_d = 1'b0;
      end else begin
        card_oe_d = ~host_in_i[p] & ~host_oe_q;
        host_oe_d = ~card_in_i[p] & ~card_oe_q & ~card_oe_d;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        card_oe_q <= 1'b1;
        host_oe_q <= 1'b0;
      end else begin
        card_oe_q <= card_oe_d;
        host_oe_q <= host_oe_d;
      end
    end

    assign card_oe_o[p] = card_oe_q;
    assign host_oe_o[p] = host_oe_q;

    p_host_released_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      isolate_i |=> !host_oe_o[p]);
    p_no_double_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(host_oe_o[p] && card_oe_o[p]));
  end
endmodule

// File: rtl/sc_clk_switch.sv
module sc_clk_switch
  import sc_pin_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_clk_i,
  input  logic hold_i,
  input  logic level_i,
  output logic card_clk_o
);
  logic [SYNC_STAGES-1:0] hold_sync_q;
  logic                   hold_req;
  logic                   src_q;
  logic                   clk_q;
  ck_state_e              state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_sync_q <= '1;
    else         hold_sync_q <= {hold_sync_q[SYNC_STAGES-2:0], hold_i};
  end
  assign hold_req = hold_sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CK_HOLD;
      clk_q   <= 1'b0;
      src_q   <= 1'b0;
    end else begin
      src_q <= src_clk_i;
      unique case (state_q)
        CK_RUN: begin
          // freeze only once source already sits at the hold level
          if (hold_req && (src_clk_i == level_i)) begin
            state_q <= CK_HOLD;
            clk_q   <= level_i;
          end else begin
            clk_q   <= src_clk_i;
          end
        end
        CK_HOLD: begin
          // rejoin only on a source edge so no phase is cut short
          if (!hold_req && (src_clk_i != src_q)) begin
            state_q <= CK_RUN;
            clk_q   <= src_clk_i;
          end else begin
            clk_q   <= level_i;
          end
        end
        default: state_q <= CK_HOLD;
      endcase
    end
  end

  assign card_clk_o = clk_q;

  p_clk_edge_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(card_clk_o) |-> (($past(src_clk_i) != $past(src_clk_i, 2)) ||
                              ($past(level_i) != $past(level_i, 2))));
  p_hold_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CK_HOLD && $past(state_q) == CK_HOLD) |-> (card_clk_o == $past(level_i)));
endmodule

// File: rtl/sc_in_sync.sv
module sc_in_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sc_pin_ctrl.sv
module sc_pin_ctrl
  import sc_pin_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_data_i,
  output logic [REG_W-1:0]    rd_data_o,
  input  logic                src_clk_i,
  input  logic [NUM_PINS-1:0] host_in_i,
  output logic [NUM_PINS-1:0] host_oe_o,
  input  logic [NUM_PINS-1:0] card_in_i,
  output logic [NUM_PINS-1:0] card_oe_o,
  output logic                card_clk_o,
  output logic                card_rst_o,
  output logic [NUM_PINS-1:0] status_o
);
  ctrl_reg_t           ctrl;
  logic [NUM_PINS-1:0] sw_bits;

  sc_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl),
    .rd_data_o (rd_data_o)
  );

  assign sw_bits = {ctrl.c8_bit, ctrl.c4_bit, ctrl.io_bit};

  sc_pin_route #(.PINS(NUM_PINS)) u_route (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .isolate_i (ctrl.isolate),
    .sw_bits_i (sw_bits),
    .host_in_i (host_in_i),
    .card_in_i (card_in_i),
    .host_oe_o (host_oe_o),
    .card_oe_o (card_oe_o)
  );

  sc_clk_switch #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_clk_i  (src_clk_i),
    .hold_i     (ctrl.clk_hold),
    .level_i    (ctrl.clk_lvl),
    .card_clk_o (card_clk_o)
  );

  sc_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (card_in_i),
    .q_o    (status_o)
  );

  assign card_rst_o = ctrl.card_rst;

  p_rst_follows_reg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[4]) |=> !card_rst_o);
endmodule

// File: tb/sc_pin_ctrl_test.sv
module sc_pin_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       src_clk = 1'b0;
  logic [2:0] host_ext = 3'b111, card_ext = 3'b111;
  logic [2:0] host_in, card_in, host_oe, card_oe, status;
  logic       card_clk, card_rst;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0, src_run = 0;
  logic [1:0] src_div = '0;
  logic       src_prev = 1'b0;

  always #5 clk = ~clk;

  assign host_in = host_ext & ~host_oe;
  assign card_in = card_ext & ~card_oe;

  always @(posedge clk) begin
    src_prev <= src_clk;
    if (src_run) begin
      src_div <= src_div + 2'd1;
      if (src_div[0]) src_clk <= ~src_clk;
    end
  end

  sc_pin_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .src_clk_i(src_clk), .host_in_i(host_in),
    .host_oe_o(host_oe), .card_in_i(card_in), .card_oe_o(card_oe),
    .card_clk_o(card_clk), .card_rst_o(card_rst), .status_o(status)
  );

  // phase-length monitor for R7
  int  run_len = 0;
  int  short_phases = 0;
  logic last_clk = 1'b0;
  bit  mon_on = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (card_clk != last_clk) begin
        if (run_len < 2) short_phases++;
        run_len = 1;
      end else run_len++;
    end
    last_clk = card_clk;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  localparam int NV = 8;
  localparam logic [7:0] V_WD  [NV] = '{8'h60, 8'h6D, 8'h65, 8'h20, 8'h20, 8'h20, 8'h20, 8'hF0};
  localparam logic [2:0] V_HX  [NV] = '{3'h7, 3'h7, 3'h0, 3'h7, 3'h6, 3'h7, 3'h6, 3'h7};
  localparam logic [2:0] V_CX  [NV] = '{3'h7, 3'h7, 3'h7, 3'h7, 3'h7, 3'h5, 3'h3, 3'h7};
  localparam logic [2:0] V_COE [NV] = '{3'h7, 3'h0, 3'h4, 3'h0, 3'h1, 3'h0, 3'h1, 3'h7};
  localparam logic [2:0] V_HOE [NV] = '{3'h0, 3'h0, 3'h0, 3'h0, 3'h0, 3'h2, 3'h4, 3'h0};
  localparam logic [2:0] V_ST  [NV] = '{3'h0, 3'h7, 3'h3, 3'h7, 3'h6, 3'h5, 3'h2, 3'h0};

  initial begin
    wait_cyc(3);
    // R2 reset state
    chk("R2 rd_data", rd_data, 8'h60);
    chk("R2 card_oe", {5'd0, card_oe}, 8'h07);
    chk("R2 host_oe", {5'd0, host_oe}, 8'h00);
    chk("R2 card_clk", {7'd0, card_clk}, 8'h00);
    chk("R2 card_rst", {7'd0, card_rst}, 8'h00);
    rst_n = 1'b1;
    wait_cyc(2);

    for (int v = 0; v < NV; v++) begin
      host_ext = V_HX[v];
      card_ext = V_CX[v];
      wr(V_WD[v]);
      wait_cyc(6);
      chk($sformatf("R1 read v%0d", v), rd_data, V_WD[v] & 8'h7F);
      chk($sformatf("R3/R4 card_oe v%0d", v), {5'd0, card_oe}, {5'd0, V_COE[v]});
      chk($sformatf("R3/R4 host_oe v%0d", v), {5'd0, host_oe}, {5'd0, V_HOE[v]});
      chk($sformatf("R9 status v%0d", v), {5'd0, status}, {5'd0, V_ST[v]});
      chk($sformatf("R8 card_rst v%0d", v), {7'd0, card_rst}, {7'd0, V_WD[v][4]});
    end

    // R3 latency: one cycle after register update
    host_ext = 3'b111; card_ext = 3'b111;
    wr(8'h60);
    wait_cyc(3);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h62 | 8'h01;
    @(negedge clk); wr_en = 1'b0;
    chk("R3 latency pre", {5'd0, card_oe}, 8'h07);
    @(negedge clk);
    chk("R3 latency post", {5'd0, card_oe}, 8'h06);

    // R4 both sides low together, then host releases
    wr(8'h20);
    wait_cyc(4);
    host_ext = 3'b110; card_ext = 3'b110;
    wait_cyc(4);
    chk("R4 both low card_oe", {5'd0, card_oe}, 8'h01);
    chk("R4 both low host_oe", {5'd0, host_oe}, 8'h00);
    host_ext = 3'b111;
    wait_cyc(4);
    chk("R4 release card_oe", {5'd0, card_oe}, 8'h00);
    chk("R4 release host_oe", {5'd0, host_oe}, 8'h01);
    card_ext = 3'b111;
    wait_cyc(4);
    chk("R4 idle host_oe", {5'd0, host_oe}, 8'h00);

    // clock: start source, enable monitor
    wr(8'h60);
    src_run = 1;
    wait_cyc(4);
    mon_on = 1;
    for (int rep = 0; rep < 3; rep++) begin
      wr(8'h40);
      wait_cyc(8);
      for (int i = 0; i < 8; i++) begin
        chk("R6 follow src", {7'd0, card_clk}, {7'd0, src_prev});
        @(negedge clk);
      end
      wr((rep == 1) ? 8'h60 : 8'h62);
      wait_cyc(8);
      for (int i = 0; i < 6; i++) begin
        chk("R5 held level", {7'd0, card_clk}, (rep == 1) ? 8'h00 : 8'h01);
        @(negedge clk);
      end
      wait_cyc(rep + 1);
    end
    // software level change while held
    wr(8'h60);
    wait_cyc(3);
    chk("R5 level change", {7'd0, card_clk}, 8'h00);
    wait_cyc(4);
    wr(8'h40);
    wait_cyc(10);
    chk("R6 rejoin src", {7'd0, card_clk}, {7'd0, src_prev});
    mon_on = 0;
    chk("R7 no short phase", short_phases[7:0], 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule